// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic datapath of a small accumulator-style processor core. On each clock it receives an operation code, the current accumulator byte, a second operand byte, the current auxiliary (B) register byte and an incoming carry. It produces the new accumulator byte, the new B byte and a four-flag status word. All three are held in registers and update on the clock edge that follows the inputs.

Addition, subtraction with borrow and the logical, rotate and single-bit operations take one operand from the accumulator and write their result back to it. Multiply and divide pair the accumulator with B: the 16-bit product is split across the two registers, and division leaves the quotient in one and the remainder in the other. Beside carry, the status word keeps an auxiliary carry for decimal adjustment, a signed-overflow flag and an accumulator parity flag. Each operation leaves untouched any flag it does not define.

Fetch, decode, memory access and register-file storage belong to the surrounding core. The caller feeds back whatever accumulator, B and carry values it wants the next operation to use.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low at a rising edge, `acc_q`, `b_q` and `stat_q` all become zero. Otherwise all three update on every rising edge from the inputs present at that edge. Status bit layout: bit 3 carry, bit 2 auxiliary carry, bit 1 overflow, bit 0 parity.
- R2: ADD (code 1) gives `acc_in + opnd_in`, and ADDC (code 2) gives `acc_in + opnd_in + cy_in`. In both, the low byte goes to the accumulator, carry is the carry out of bit 7, auxiliary carry is the carry out of bit 3, and overflow is set when the two addends share a sign that the result does not.
- R3: SUBB (code 3) gives `acc_in - opnd_in - cy_in`. Carry is set on a borrow out of bit 7, auxiliary carry on a borrow into bit 3 from bit 4, and overflow when the operands differ in sign and the result's sign differs from `acc_in`'s.
- R4: MUL (code 4) forms `acc_in * b_in`. The low byte goes to the accumulator and the high byte to B. Overflow is set exactly when the product exceeds 255, carry is cleared and auxiliary carry is held.
- R5: DIV (code 5) with a nonzero `b_in` puts the quotient `acc_in / b_in` in the accumulator and the remainder in B, and clears carry and overflow. With `b_in` zero it sets overflow and clears carry, and the accumulator and B contents are unspecified. Auxiliary carry is held in both cases.
- R6: AND (6), OR (7) and XOR (8) combine `acc_in` with `opnd_in`, and CPL (9) inverts `acc_in`. Carry, auxiliary carry and overflow are held.
- R7: RL (10) and RR (11) rotate `acc_in` left or right by one bit within the byte, and carry is held. RLC (12) and RRC (13) rotate through carry: `cy_in` enters the vacated bit and the bit shifted out becomes carry.
- R8: The single-bit operations select accumulator bit `opnd_in[2:0]`. SETB (14) sets it, CLRB (15) clears it and CPLB (16) inverts it, with carry held. TSTB (17) copies the bit into carry and leaves the accumulator equal to `acc_in`.
- R9: The parity bit is always the XOR of the eight bits of `acc_q`, which makes it 1 for an odd count of ones.
- R10: Every operation except MUL and DIV passes `b_in` to B. NOP (code 0) and the unused codes 18 to 31 pass `acc_in` to the accumulator and hold carry, auxiliary carry and overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand, or bit index in its low three bits |
| b_in | input | 8 | Current B register value |
| cy_in | input | 1 | Incoming carry |
| acc_q | output | 8 | Registered accumulator result |
| b_q | output | 8 | Registered B result |
| stat_q | output | 4 | Registered status word {carry, aux carry, overflow, parity} |

## Verification
Two functions can land in the same cycle. A multiply that overflows sets the overflow flag while the parity flag is recomputed from the new low byte. An add or subtract changes carry and auxiliary carry together, and each flag must come from its own bit position. Directed operands provoke these overlaps: products of exactly 256 and 65025, 0x7F+1, 0x0F+1, 0xFF+1 and 0x80-1. A long pseudo-random run over all 32 codes follows. A behavioural model in the bench, which keeps its own held flags, is compared against every field on every clock. Only the accumulator, B and parity after a divide by zero are left unchecked, because those values are unspecified.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes and the status flag record for the
// accumulator ALU. Assumes a 5-bit operation code, where unlisted values act
// as a no-operation.
package acc_alu_pkg;

    localparam int OP_W = 5;

    typedef enum logic [OP_W-1:0] {
        OP_NOP  = 5'd0,
        OP_ADD  = 5'd1,
        OP_ADDC = 5'd2,
        OP_SUBB = 5'd3,
        OP_MUL  = 5'd4,
        OP_DIV  = 5'd5,
        OP_AND  = 5'd6,
        OP_OR   = 5'd7,
        OP_XOR  = 5'd8,
        OP_CPL  = 5'd9,
        OP_RL   = 5'd10,
        OP_RR   = 5'd11,
        OP_RLC  = 5'd12,
        OP_RRC  = 5'd13,
        OP_SETB = 5'd14,
        OP_CLRB = 5'd15,
        OP_CPLB = 5'd16,
        OP_TSTB = 5'd17
    } op_e;

    // Flag update record: a value plus a write strobe per flag.
    typedef struct packed {
        logic cy;
        logic ac;
        logic ov;
        logic wr_cy;
        logic wr_ac;
        logic wr_ov;
    } flag_upd_t;

endpackage

// File: rtl/acc_alu_arith.sv
// Module: arithmetic unit. Covers add, add with carry, subtract with borrow,
// multiply and divide. Purely combinational. Assumes W is even, so that the
// auxiliary carry sits at the half-width boundary. Drives `hit` for the
// operations it owns, and reports which flags it writes.
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e        op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] o,
    input  logic [W-1:0] b,
    input  logic       cin,
    output logic       hit,
    output logic [W-1:0] res_a,
    output logic [W-1:0] res_b,
    output flag_upd_t  fl
);

    localparam int H = W / 2;

    logic [W:0]     add_w;
    logic [H:0]     add_h;
    logic [W:0]     sub_w;
    logic [H:0]     sub_h;
    logic           c_use;
    logic [2*W-1:0] prod;
    logic [W-1:0]   quo;
    logic [W-1:0]   rem;
    logic           b_zero;

    // Carry-in is used by ADDC and SUBB only.
    always_comb c_use = (op == OP_ADDC || op == OP_SUBB) ? cin : 1'b0;

    // Full-width and half-width sums and differences.
    always_comb begin
        add_w = {1'b0, a} + {1'b0, o} + {{W{1'b0}}, c_use};
        add_h = {1'b0, a[H-1:0]} + {1'b0, o[H-1:0]} + {{H{1'b0}}, c_use};
        sub_w = {1'b0, a} - {1'b0, o} - {{W{1'b0}}, c_use};
        sub_h = {1'b0, a[H-1:0]} - {1'b0, o[H-1:0]} - {{H{1'b0}}, c_use};
    end

    // Product and guarded quotient/remainder.
    always_comb begin
        prod   = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        b_zero = (b == '0);
        quo    = b_zero ? a : (a / b);
        rem    = b_zero ? b : (a % b);
    end

    // Result and flag selection per operation.
    always_comb begin
        hit   = 1'b1;
        res_a = a;
        res_b = b;
        fl    = '0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                res_a    = add_w[W-1:0];
                fl.cy    = add_w[W];
                fl.ac    = add_h[H];
                fl.ov    = (a[W-1] == o[W-1]) && (add_w[W-1] != a[W-1]);
                fl.wr_cy = 1'b1;
                fl.wr_ac = 1'b1;
                fl.wr_ov = 1'b1;
            end
            OP_SUBB: begin
                res_a    = sub_w[W-1:0];
                fl.cy    = sub_w[W];
                fl.ac    = sub_h[H];
                fl.ov    = (a[W-1] != o[W-1]) && (sub_w[W-1] != a[W-1]);
                fl.wr_cy = 1'b1;
                fl.wr_ac = 1'b1;
                fl.wr_ov = 1'b1;
            end
            OP_MUL: begin
                res_a    = prod[W-1:0];
                res_b    = prod[2*W-1:W];
                fl.cy    = 1'b0;
                fl.ov    = |prod[2*W-1:W];
                fl.wr_cy = 1'b1;
                fl.wr_ov = 1'b1;
            end
            OP_DIV: begin
                res_a    = quo;
                res_b    = rem;
                fl.cy    = 1'b0;
                fl.ov    = b_zero;
                fl.wr_cy = 1'b1;
                fl.wr_ov = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_alu_logic.sv
// Module: logic unit. Covers AND/OR/XOR/complement, the four rotates and the
// single-bit set/clear/complement/test. Purely combinational. Assumes W is a
// power of two, so that the low log2(W) operand bits index a bit.
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e        op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] o,
    input  logic       cin,
    output logic       hit,
    output logic [W-1:0] res_a,
    output logic       cy,
    output logic       wr_cy
);

    localparam int IW = $clog2(W);

    logic [W-1:0] sel_mask;
    logic         sel_bit;

    // One-hot mask of the addressed bit, one decoder per position.
    for (genvar i = 0; i < W; i++) begin : g_mask
        assign sel_mask[i] = (o[IW-1:0] == IW'(i));
    end

    // Value of the addressed accumulator bit.
    always_comb sel_bit = |(a & sel_mask);

    // Result and carry selection per operation.
    always_comb begin
        hit   = 1'b1;
        res_a = a;
        cy    = 1'b0;
        wr_cy = 1'b0;
        unique case (op)
            OP_AND:  res_a = a & o;
            OP_OR:   res_a = a | o;
            OP_XOR:  res_a = a ^ o;
            OP_CPL:  res_a = ~a;
            OP_RL:   res_a = {a[W-2:0], a[W-1]};
            OP_RR:   res_a = {a[0], a[W-1:1]};
            OP_RLC: begin
                res_a = {a[W-2:0], cin};
                cy    = a[W-1];
                wr_cy = 1'b1;
            end
            OP_RRC: begin
                res_a = {cin, a[W-1:1]};
                cy    = a[0];
                wr_cy = 1'b1;
            end
            OP_SETB: res_a = a | sel_mask;
            OP_CLRB: res_a = a & ~sel_mask;
            OP_CPLB: res_a = a ^ sel_mask;
            OP_TSTB: begin
                cy    = sel_bit;
                wr_cy = 1'b1;
            end
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/acc_alu_parity.sv
// Module: parity of a W-bit word, built as an explicit XOR chain. Output is
// 1 for an odd count of ones.
module acc_alu_parity #(
    parameter int W = 8
) (
    input  logic [W-1:0] d,
    output logic         par
);

    logic [W-1:0] chain;

    assign chain[0] = d[0];
    // Each stage folds in one more bit.
    for (genvar i = 1; i < W; i++) begin : g_chain
        assign chain[i] = chain[i-1] ^ d[i];
    end

    assign par = chain[W-1];

endmodule

// File: rtl/acc_alu.sv
// Module: accumulator ALU top. Picks the result from the arithmetic or logic
// unit, merges the flag updates with the held flags, and registers the
// accumulator, B and status word. Assumes the caller feeds back acc_q, b_q
// and carry as it sees fit. Reset is synchronous and active low.
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [4:0]   op_sel,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    input  logic [W-1:0] b_in,
    input  logic         cy_in,
    output logic [W-1:0] acc_q,
    output logic [W-1:0] b_q,
    output logic [3:0]   stat_q
);

    op_e          op;
    logic         ar_hit;
    logic [W-1:0] ar_a;
    logic [W-1:0] ar_b;
    flag_upd_t    ar_fl;
    logic         lg_hit;
    logic [W-1:0] lg_a;
    logic         lg_cy;
    logic         lg_wr_cy;
    logic [W-1:0] acc_d;
    logic [W-1:0] b_d;
    logic         cy_q, ac_q, ov_q, p_q;
    logic         cy_d, ac_d, ov_d, p_d;

    // Decode the raw code into the operation type.
    always_comb op = op_e'(op_sel);

    acc_alu_arith #(.W(W)) u_arith (
        .op    (op),
        .a     (acc_in),
        .o     (opnd_in),
        .b     (b_in),
        .cin   (cy_in),
        .hit   (ar_hit),
        .res_a (ar_a),
        .res_b (ar_b),
        .fl    (ar_fl)
    );

    acc_alu_logic #(.W(W)) u_logic (
        .op    (op),
        .a     (acc_in),
        .o     (opnd_in),
        .cin   (cy_in),
        .hit   (lg_hit),
        .res_a (lg_a),
        .cy    (lg_cy),
        .wr_cy (lg_wr_cy)
    );

    acc_alu_parity #(.W(W)) u_par (
        .d   (acc_d),
        .par (p_d)
    );

    // Result selection: arithmetic, then logic, else pass-through.
    always_comb begin
        acc_d = acc_in;
        b_d   = b_in;
        if (ar_hit) begin
            acc_d = ar_a;
            b_d   = ar_b;
        end else if (lg_hit) begin
            acc_d = lg_a;
        end
    end

    // Flag merge: a written flag takes the new value, the others hold.
    always_comb begin
        cy_d = cy_q;
        ac_d = ac_q;
        ov_d = ov_q;
        if (ar_hit) begin
            if (ar_fl.wr_cy) cy_d = ar_fl.cy;
            if (ar_fl.wr_ac) ac_d = ar_fl.ac;
            if (ar_fl.wr_ov) ov_d = ar_fl.ov;
        end else if (lg_hit && lg_wr_cy) begin
            cy_d = lg_cy;
        end
    end

    // Output and flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            b_q   <= '0;
            cy_q  <= 1'b0;
            ac_q  <= 1'b0;
            ov_q  <= 1'b0;
            p_q   <= 1'b0;
        end else begin
            acc_q <= acc_d;
            b_q   <= b_d;
            cy_q  <= cy_d;
            ac_q  <= ac_d;
            ov_q  <= ov_d;
            p_q   <= p_d;
        end
    end

    assign stat_q = {cy_q, ac_q, ov_q, p_q};

    // R9: parity flag always matches the registered accumulator.
    p_parity_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[0] == ^acc_q);

    // R4: a multiply clears carry and flags a product above the byte range.
    p_mul_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 5'd4) |->
        (!stat_q[3] && stat_q[1] == ($past(acc_in) * $past(b_in) > 255)));

    // R5: dividing by zero raises overflow.
    p_div_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 5'd5 && $past(b_in) == '0) |->
        (stat_q[1] && !stat_q[3]));

    // R6: logical operations keep carry, aux carry and overflow.
    p_logic_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) >= 5'd6 && $past(op_sel) <= 5'd9) |->
        $stable(stat_q[3:1]));

    // R8: a bit test never changes the accumulator.
    p_test_keeps_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 5'd17) |-> (acc_q == $past(acc_in)));

    // R10: unused codes hold flags and pass the operands through.
    p_unused_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) >= 5'd18) |->
        ($stable(stat_q[3:1]) && acc_q == $past(acc_in) && b_q == $past(b_in)));

endmodule

// File: tb/sim_acc_alu.sv
// Bench: behavioural reference model of the accumulator ALU, compared on
// every clock. Inputs are driven at the falling edge and outputs are
// compared at the next falling edge.
module sim_acc_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] op_sel;
    logic [7:0] acc_in, opnd_in, b_in;
    logic       cy_in;
    logic [7:0] acc_q, b_q;
    logic [3:0] stat_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Model state: expected outputs and held flags.
    int e_acc = 0, e_b = 0, e_cy = 0, e_ac = 0, e_ov = 0;
    bit e_skip = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_sel  (op_sel),
        .acc_in  (acc_in),
        .opnd_in (opnd_in),
        .b_in    (b_in),
        .cy_in   (cy_in),
        .acc_q   (acc_q),
        .b_q     (b_q),
        .stat_q  (stat_q)
    );

    function automatic int parity8(int v);
        int p = 0;
        for (int i = 0; i < 8; i++) p ^= (v >> i) & 1;
        return p;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Map an operation code to the requirement tag it exercises.
    function automatic string tag(int op);
        case (op)
            1, 2:          return "R2";
            3:             return "R3";
            4:             return "R4";
            5:             return "R5";
            6, 7, 8, 9:    return "R6";
            10, 11, 12, 13: return "R7";
            14, 15, 16, 17: return "R8";
            default:       return "R10";
        endcase
    endfunction

    string cur_tag = "R1";

    // Compare all outputs with the model's expectation.
    task automatic compare();
        if (!e_skip) begin
            chk(cur_tag, "acc", int'(acc_q), e_acc);
            chk(cur_tag, "b", int'(b_q), e_b);
            chk("R9", "parity", int'(stat_q[0]), parity8(e_acc));
        end
        chk(cur_tag, "carry", int'(stat_q[3]), e_cy);
        chk(cur_tag, "auxcarry", int'(stat_q[2]), e_ac);
        chk(cur_tag, "overflow", int'(stat_q[1]), e_ov);
    endtask

    // Drive one operation, update the model, and compare one cycle later.
    task automatic apply(int op, int a, int o, int b, int c);
        int r = a;
        int nb = b;
        int s;
        op_sel  = 5'(op);
        acc_in  = 8'(a);
        opnd_in = 8'(o);
        b_in    = 8'(b);
        cy_in   = 1'(c);
        e_skip  = 0;
        case (op)
            1, 2: begin
                int cc = (op == 2) ? c : 0;
                s = a + o + cc;
                e_cy = (s > 255) ? 1 : 0;
                e_ac = (((a & 15) + (o & 15) + cc) > 15) ? 1 : 0;
                e_ov = (((a ^ s) & (o ^ s) & 128) != 0) ? 1 : 0;
                r = s & 255;
            end
            3: begin
                s = a - o - c;
                e_cy = (s < 0) ? 1 : 0;
                e_ac = ((a & 15) < (o & 15) + c) ? 1 : 0;
                e_ov = (((a ^ o) & (a ^ s) & 128) != 0) ? 1 : 0;
                r = s & 255;
            end
            4: begin
                s = a * b;
                r = s & 255;
                nb = s >> 8;
                e_cy = 0;
                e_ov = (s > 255) ? 1 : 0;
            end
            5: begin
                e_cy = 0;
                if (b == 0) begin
                    e_ov = 1;
                    e_skip = 1;
                end else begin
                    r = a / b;
                    nb = a % b;
                    e_ov = 0;
                end
            end
            6: r = a & o;
            7: r = a | o;
            8: r = a ^ o;
            9: r = (~a) & 255;
            10: r = ((a << 1) | (a >> 7)) & 255;
            11: r = (a >> 1) | ((a & 1) << 7);
            12: begin r = ((a << 1) | c) & 255; e_cy = a >> 7; end
            13: begin r = (a >> 1) | (c << 7); e_cy = a & 1; end
            14: r = a | (1 << (o & 7));
            15: r = a & ~(1 << (o & 7)) & 255;
            16: r = a ^ (1 << (o & 7));
            17: e_cy = (a >> (o & 7)) & 1;
            default: ;
        endcase
        e_acc = r;
        e_b = nb;
        cur_tag = tag(op);
        @(negedge clk);
        compare();
    endtask

    // Main stimulus: reset, directed corners, then a pseudo-random sweep.
    initial begin
        rst_n = 1'b0;
        op_sel = 5'd0; acc_in = 8'h5A; opnd_in = 8'h33; b_in = 8'hC3; cy_in = 1'b1;
        repeat (3) @(negedge clk);
        cur_tag = "R1";
        compare();
        rst_n = 1'b1;
        // R2: add corners
        apply(1, 8'h7F, 8'h01, 8'h00, 1);
        apply(1, 8'h0F, 8'h01, 8'h00, 0);
        apply(1, 8'hFF, 8'h01, 8'h00, 0);
        apply(2, 8'h80, 8'h7F, 8'h12, 1);
        apply(2, 8'h80, 8'h80, 8'h12, 0);
        // R3: subtract with borrow corners
        apply(3, 8'h80, 8'h01, 8'h00, 0);
        apply(3, 8'h00, 8'h00, 8'h00, 1);
        apply(3, 8'h10, 8'h01, 8'h00, 0);
        apply(3, 8'h7F, 8'hFF, 8'h00, 0);
        // R4: multiply, overflow with parity in the same cycle
        apply(4, 8'h10, 8'h00, 8'h10, 0);
        apply(4, 8'hFF, 8'h00, 8'hFF, 1);
        apply(4, 8'h0F, 8'h00, 8'h11, 1);
        // R5: divide, including divide by zero
        apply(5, 8'hFF, 8'h00, 8'h01, 1);
        apply(5, 8'h64, 8'h00, 8'h07, 0);
        apply(5, 8'h64, 8'h00, 8'h00, 0);
        apply(5, 8'h03, 8'h00, 8'h09, 1);
        // R6, R7, R8, R10 directed
        apply(1, 8'h7F, 8'h01, 8'h00, 0);
        apply(6, 8'hF0, 8'h3C, 8'h01, 1);
        apply(9, 8'h55, 8'h00, 8'h02, 0);
        apply(12, 8'h80, 8'h00, 8'h00, 0);
        apply(13, 8'h01, 8'h00, 8'h00, 1);
        apply(10, 8'h81, 8'h00, 8'h00, 0);
        apply(11, 8'h81, 8'h00, 8'h00, 0);
        apply(14, 8'h00, 8'hFF, 8'h00, 0);
        apply(15, 8'hFF, 8'h08, 8'h00, 0);
        apply(16, 8'hA5, 8'h03, 8'h00, 0);
        apply(17, 8'h80, 8'h07, 8'h00, 0);
        apply(17, 8'h80, 8'h06, 8'h00, 1);
        apply(0, 8'h3C, 8'h11, 8'h22, 1);
        apply(18, 8'h3D, 8'h11, 8'h23, 0);
        apply(31, 8'hE1, 8'h11, 8'h24, 1);
        // Pseudo-random sweep over all codes
        for (int n = 0; n < 3000; n++) begin
            apply($urandom_range(0, 31), $urandom_range(0, 255),
                  $urandom_range(0, 255), $urandom_range(0, 255),
                  $urandom_range(0, 1));
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: an expired run counts as a failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule